// File: doc/BRIEF.md
# Execute-Stage Operand Bypass Selector

This block decides, for each of the two operands entering the execute stage of a five-stage integer pipeline, whether the value read from the register file is still current or whether a newer value must be taken from a later stage. It compares the two source register numbers of the instruction now in execute with the destination numbers of the two instructions ahead of it. One is one stage ahead, in the memory-access slot. The other is two stages ahead, in the write-back slot. A read-after-write conflict is then served from the pipeline registers and needs no stall.

For each operand the block gives a 2-bit select code and the operand value that code picks. The value from the write-back slot is first chosen between the load data and the older ALU result by that slot's memory-to-register flag. A one-deep output register captures both operands when `in_vld` is high, so the block can be exercised as an ordinary pipeline stage. The pipeline advances every cycle, so there is no ready input: the consumer cannot push back. A cycle with `in_vld` low leaves the captured operands untouched.

Top module: `fwd_operand_stage`

## Requirements
- R1: When no later stage supplies an operand, its select code is 2'b00 and the operand equals the register-file value given for that source.
- R2: When the memory-access slot has its write flag set and a nonzero destination equal to an operand's source number, that operand's select is 2'b10 and its value is `exm_res`.
- R3: When the memory-access slot does not supply an operand and the write-back slot has its write flag set and a nonzero destination equal to the source, the select is 2'b01 and the value is the write-back value.
- R4: When both slots match the same source, the memory-access slot (the younger result) wins and the select is 2'b10.
- R5: A destination of register 0 is never bypassed: a source of 0 always gives select 2'b00.
- R6: A slot whose write flag is clear never supplies an operand, whatever its destination number.
- R7: Operand A is resolved against `src_a` only and operand B against `src_b` only. The two are decided independently.
- R8: The write-back value is `mwb_ld` when `mwb_m2r` is 1 and `mwb_res` when it is 0.
- R9: `out_vld` equals `in_vld` of the previous cycle. When `in_vld` was high, `opa_q` and `opb_q` equal the previous cycle's `opa` and `opb`. Reset clears `out_vld`, `opa_q` and `opb_q` to 0.
- R10: A cycle with `in_vld` low leaves `opa_q` and `opb_q` unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_vld | input | 1 | Execute slot holds a valid instruction |
| src_a | input | 5 | Source register number of operand A |
| src_b | input | 5 | Source register number of operand B |
| rf_a | input | 32 | Register-file value latched for operand A |
| rf_b | input | 32 | Register-file value latched for operand B |
| exm_we | input | 1 | Memory-access slot writes a register |
| exm_rd | input | 5 | Memory-access slot destination number |
| exm_res | input | 32 | ALU result held in the memory-access slot |
| mwb_we | input | 1 | Write-back slot writes a register |
| mwb_rd | input | 5 | Write-back slot destination number |
| mwb_m2r | input | 1 | Write-back slot carries load data (1) or ALU result (0) |
| mwb_ld | input | 32 | Load data in the write-back slot |
| mwb_res | input | 32 | ALU result in the write-back slot |
| sel_a | output | 2 | Select code for operand A (00 reg, 10 mem slot, 01 wb slot) |
| sel_b | output | 2 | Select code for operand B |
| opa | output | 32 | Resolved operand A |
| opb | output | 32 | Resolved operand B |
| out_vld | output | 1 | Registered operands are valid |
| opa_q | output | 32 | Registered operand A |
| opb_q | output | 32 | Registered operand B |

## Verification
A sweep drives source and destination numbers over registers 0 to 3 for every combination of both write flags and the memory-to-register flag. The small register range makes matches, double matches and register-0 cases dense. It separates a back-to-back dependency (memory-access slot), a dependency two instructions apart (write-back slot), a double match where priority decides, and writes to register 0 or with a clear write flag that must fall back to the register file. Each data input carries a distinct value, so a wrong multiplexer leg shows up as a wrong operand and not only as a wrong code. Directed cases add register 31 and a cycle with `in_vld` low to show that the output register holds.

// File: rtl/fwd_pkg.sv
package fwd_pkg;
  // Operand source codes; the encoding is seen at the select ports.
  typedef enum logic [1:0] {
    SRC_RF  = 2'b00,
    SRC_MWB = 2'b01,
    SRC_EXM = 2'b10
  } fwd_src_e;
endpackage

// File: rtl/fwd_match.sv
module fwd_match #(
  parameter int REG_AW = 5
) (
  input  logic [REG_AW-1:0] src,
  input  logic              exm_we,
  input  logic [REG_AW-1:0] exm_rd,
  input  logic              mwb_we,
  input  logic [REG_AW-1:0] mwb_rd,
  output fwd_pkg::fwd_src_e sel
);
  logic exm_hit, mwb_hit;

  // A slot supplies the operand only if it writes, is not register 0 and matches.
  assign exm_hit = exm_we && (exm_rd != '0) && (exm_rd == src);
  assign mwb_hit = mwb_we && (mwb_rd != '0) && (mwb_rd == src);

  // The nearer slot holds the younger result, so it is checked first.
  always_comb begin
    if (exm_hit)      sel = fwd_pkg::SRC_EXM;
    else if (mwb_hit) sel = fwd_pkg::SRC_MWB;
    else              sel = fwd_pkg::SRC_RF;
  end
endmodule

// File: rtl/fwd_wb_value.sv
module fwd_wb_value #(
  parameter int DATA_W = 32
) (
  input  logic              m2r,
  input  logic [DATA_W-1:0] ld,
  input  logic [DATA_W-1:0] res,
  output logic [DATA_W-1:0] val
);
  assign val = m2r ? ld : res;
endmodule

// File: rtl/fwd_opmux.sv
module fwd_opmux #(
  parameter int DATA_W = 32
) (
  input  fwd_pkg::fwd_src_e sel,
  input  logic [DATA_W-1:0] rf_val,
  input  logic [DATA_W-1:0] exm_val,
  input  logic [DATA_W-1:0] mwb_val,
  output logic [DATA_W-1:0] op
);
  always_comb begin
    unique case (sel)
      fwd_pkg::SRC_EXM: op = exm_val;
      fwd_pkg::SRC_MWB: op = mwb_val;
      default:          op = rf_val;
    endcase
  end
endmodule

// File: rtl/fwd_operand_stage.sv
module fwd_operand_stage #(
  parameter int REG_AW = 5,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_vld,
  input  logic [REG_AW-1:0] src_a,
  input  logic [REG_AW-1:0] src_b,
  input  logic [DATA_W-1:0] rf_a,
  input  logic [DATA_W-1:0] rf_b,
  input  logic              exm_we,
  input  logic [REG_AW-1:0] exm_rd,
  input  logic [DATA_W-1:0] exm_res,
  input  logic              mwb_we,
  input  logic [REG_AW-1:0] mwb_rd,
  input  logic              mwb_m2r,
  input  logic [DATA_W-1:0] mwb_ld,
  input  logic [DATA_W-1:0] mwb_res,
  output logic [1:0]        sel_a,
  output logic [1:0]        sel_b,
  output logic [DATA_W-1:0] opa,
  output logic [DATA_W-1:0] opb,
  output logic              out_vld,
  output logic [DATA_W-1:0] opa_q,
  output logic [DATA_W-1:0] opb_q
);
  localparam int NUM_OPS = 2;

  logic [REG_AW-1:0] src_v  [NUM_OPS];
  logic [DATA_W-1:0] rf_v   [NUM_OPS];
  fwd_pkg::fwd_src_e sel_v  [NUM_OPS];
  logic [DATA_W-1:0] op_v   [NUM_OPS];
  logic [DATA_W-1:0] op_q   [NUM_OPS];
  logic [DATA_W-1:0] wb_val;

  assign src_v[0] = src_a;
  assign src_v[1] = src_b;
  assign rf_v[0]  = rf_a;
  assign rf_v[1]  = rf_b;

  fwd_wb_value #(.DATA_W(DATA_W)) u_wbv (
    .m2r(mwb_m2r), .ld(mwb_ld), .res(mwb_res), .val(wb_val)
  );

  for (genvar g = 0; g < NUM_OPS; g++) begin : g_op
    fwd_match #(.REG_AW(REG_AW)) u_match (
      .src(src_v[g]), .exm_we(exm_we), .exm_rd(exm_rd),
      .mwb_we(mwb_we), .mwb_rd(mwb_rd), .sel(sel_v[g])
    );

    fwd_opmux #(.DATA_W(DATA_W)) u_mux (
      .sel(sel_v[g]), .rf_val(rf_v[g]), .exm_val(exm_res),
      .mwb_val(wb_val), .op(op_v[g])
    );

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      op_q[g] <= '0;
      else if (in_vld) op_q[g] <= op_v[g];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) out_vld <= 1'b0;
    else        out_vld <= in_vld;
  end

  assign sel_a = sel_v[0];
  assign sel_b = sel_v[1];
  assign opa   = op_v[0];
  assign opb   = op_v[1];
  assign opa_q = op_q[0];
  assign opb_q = op_q[1];
endmodule

// File: rtl/fwd_operand_chk.sv
module fwd_operand_chk #(
  parameter int REG_AW = 5,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_vld,
  input logic [REG_AW-1:0] src_a,
  input logic [REG_AW-1:0] src_b,
  input logic [DATA_W-1:0] rf_a,
  input logic              exm_we,
  input logic [REG_AW-1:0] exm_rd,
  input logic [DATA_W-1:0] exm_res,
  input logic              mwb_we,
  input logic [REG_AW-1:0] mwb_rd,
  input logic [1:0]        sel_a,
  input logic [1:0]        sel_b,
  input logic [DATA_W-1:0] opa,
  input logic              out_vld,
  input logic [DATA_W-1:0] opa_q
);
  assert_near_wins_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (exm_we && exm_rd != '0 && exm_rd == src_a) |-> (sel_a == 2'b10 && opa == exm_res));

  assert_near_wins_b_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (exm_we && exm_rd != '0 && exm_rd == src_b) |-> sel_b == 2'b10);

  assert_far_only_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!(exm_we && exm_rd == src_a) && mwb_we && mwb_rd != '0 && mwb_rd == src_a)
    |-> sel_a == 2'b01);

  assert_zero_src_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (src_a == '0) |-> (sel_a == 2'b00 && opa == rf_a));

  assert_vld_follow_R9: assert property (@(posedge clk) disable iff (!rst_n)
    in_vld |=> out_vld);

  assert_vld_drop_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !in_vld |=> !out_vld);

  assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !in_vld |=> $stable(opa_q));
endmodule

bind fwd_operand_stage fwd_operand_chk #(.REG_AW(REG_AW), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_vld(in_vld), .src_a(src_a), .src_b(src_b),
  .rf_a(rf_a), .exm_we(exm_we), .exm_rd(exm_rd), .exm_res(exm_res),
  .mwb_we(mwb_we), .mwb_rd(mwb_rd), .sel_a(sel_a), .sel_b(sel_b),
  .opa(opa), .out_vld(out_vld), .opa_q(opa_q)
);

// File: tb/sim_fwd_operand_stage.sv
module sim_fwd_operand_stage;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_vld = 1'b0;
  logic [4:0]  src_a = '0, src_b = '0, exm_rd = '0, mwb_rd = '0;
  logic [31:0] rf_a = '0, rf_b = '0, exm_res = '0, mwb_ld = '0, mwb_res = '0;
  logic        exm_we = 1'b0, mwb_we = 1'b0, mwb_m2r = 1'b0;
  logic [1:0]  sel_a, sel_b;
  logic [31:0] opa, opb, opa_q, opb_q;
  logic        out_vld;
  int          n_run = 0, n_fail = 0;
  logic [31:0] pend_a, pend_b;
  logic        pend = 1'b0;

  always #4 clk = ~clk;

  fwd_operand_stage u0 (
    .clk, .rst_n, .in_vld, .src_a, .src_b, .rf_a, .rf_b, .exm_we, .exm_rd,
    .exm_res, .mwb_we, .mwb_rd, .mwb_m2r, .mwb_ld, .mwb_res,
    .sel_a, .sel_b, .opa, .opb, .out_vld, .opa_q, .opb_q
  );

  function automatic logic [1:0] exp_sel(logic [4:0] s);
    if (exm_we && exm_rd != 0 && exm_rd == s) return 2'b10;
    if (mwb_we && mwb_rd != 0 && mwb_rd == s) return 2'b01;
    return 2'b00;
  endfunction

  function automatic logic [31:0] exp_val(logic [1:0] c, logic [31:0] rf);
    if (c == 2'b10) return exm_res;
    if (c == 2'b01) return mwb_m2r ? mwb_ld : mwb_res;
    return rf;
  endfunction

  function automatic string tag_of(logic [4:0] s, logic [1:0] c);
    if (c == 2'b10 && mwb_we && mwb_rd == s) return "R4";
    if (c == 2'b10) return "R2";
    if (c == 2'b01) return "R3";
    if (s == 0) return "R5";
    if ((exm_rd == s && !exm_we) || (mwb_rd == s && !mwb_we)) return "R6";
    return "R1";
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Called at a negedge: checks the register loaded at the last edge, drives, checks comb.
  task automatic step(logic [4:0] a, logic [4:0] b, logic ew, logic [4:0] er,
                      logic mw, logic [4:0] mr, logic m2r, int k);
    logic [1:0] ea, eb;
    if (pend) begin
      chk("R9", {31'd0, out_vld}, 32'd1);
      chk("R9", opa_q, pend_a);
      chk("R9", opb_q, pend_b);
    end
    src_a = a; src_b = b; exm_we = ew; exm_rd = er; mwb_we = mw; mwb_rd = mr;
    mwb_m2r = m2r; in_vld = 1'b1;
    rf_a = 32'h1100_0000 + k; rf_b = 32'h2200_0000 + k;
    exm_res = 32'h3300_0000 + k; mwb_res = 32'h4400_0000 + k; mwb_ld = 32'h5500_0000 + k;
    #1;
    ea = exp_sel(a); eb = exp_sel(b);
    chk(tag_of(a, ea), {30'd0, sel_a}, {30'd0, ea});
    chk((ea == 2'b01) ? "R8" : tag_of(a, ea), opa, exp_val(ea, rf_a));
    chk("R7", {30'd0, sel_b}, {30'd0, eb});
    chk("R7", opb, exp_val(eb, rf_b));
    pend_a = exp_val(ea, rf_a); pend_b = exp_val(eb, rf_b); pend = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    #(8 * 150000);
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] held_a, held_b;
    repeat (2) @(negedge clk);
    chk("R9", {31'd0, out_vld}, 32'd0);
    chk("R9", opa_q, 32'd0);
    chk("R9", opb_q, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    // Sweep over registers 0..3 with every flag combination.
    for (int c = 0; c < 2048; c++)
      step(5'(c & 3), 5'((c >> 2) & 3), c[8], 5'((c >> 4) & 3), c[9],
           5'((c >> 6) & 3), c[10], c);
    // Directed: back-to-back dependency R2, two apart R3, double match R4, r0 writes R5.
    step(5'd31, 5'd7, 1'b1, 5'd31, 1'b0, 5'd0, 1'b0, 9001);
    chk("R2", {30'd0, sel_a}, 32'd2);
    step(5'd7, 5'd31, 1'b1, 5'd12, 1'b1, 5'd31, 1'b1, 9002);
    chk("R3", opb, 32'h5500_0000 + 9002);
    step(5'd9, 5'd9, 1'b1, 5'd9, 1'b1, 5'd9, 1'b1, 9003);
    chk("R4", opa, 32'h3300_0000 + 9003);
    step(5'd0, 5'd0, 1'b1, 5'd0, 1'b1, 5'd0, 1'b1, 9004);
    chk("R5", opb, 32'h2200_0000 + 9004);
    step(5'd4, 5'd4, 1'b0, 5'd4, 1'b0, 5'd4, 1'b0, 9005);
    chk("R6", opa, 32'h1100_0000 + 9005);
    // Hold: in_vld low, operands change, registers must not.
    step(5'd1, 5'd2, 1'b0, 5'd0, 1'b0, 5'd0, 1'b0, 9006);
    chk("R9", opa_q, pend_a);
    held_a = opa_q; held_b = opb_q;
    pend = 1'b0; in_vld = 1'b0; rf_a = 32'hDEAD_0001; rf_b = 32'hDEAD_0002;
    @(negedge clk);
    chk("R9", {31'd0, out_vld}, 32'd0);
    chk("R10", opa_q, held_a);
    chk("R10", opb_q, held_b);
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule